// File: doc/BRIEF.md
# Compare Flag and Branch-Condition Unit

This block performs an 8-bit compare. It subtracts an operand `opM` from an accumulator value `accA`, discards the difference and keeps only the status flags. The flags are negative, overflow, zero and carry. They are captured in a flag register on a clock edge where the compare strobe is high. A combinational stage then tests the registered flags against a 3-bit branch-condition code and drives a single take-branch bit.

Signed ordering is never found with a magnitude comparator. It comes only from whether the negative and overflow flags agree. Unsigned ordering comes from the carry out of the adder. Decode, program-counter update and the rest of the ALU are outside this block.

Top module: `cmpBranchUnit`

## Requirements
- R1: The difference is formed as `accA + ~opM + 1` over 8 bits, and the negative flag `flagN` takes bit 7 of that difference.
- R2: The overflow flag `flagV` is set exactly when `accA` and `opM` differ in bit 7 and the difference's bit 7 differs from bit 7 of `accA`. This matches the signed result falling outside -128..127.
- R3: The zero flag `flagZ` is set exactly when the 8-bit difference is 0x00.
- R4: The carry flag `flagC` is the carry out of the 9-bit addition. It is 1 exactly when `accA >= opM` unsigned.
- R5: All four flags load on a rising clock edge where `cmpStrobe` is 1. On any other edge they keep their value, whatever `accA` and `opM` do.
- R6: A synchronous reset (`rst` high at a rising edge) clears all four flags and takes priority over `cmpStrobe`.
- R7: `condSel` codes 0 to 3 test one flag each: 0 branches when N=0, 1 when N=1, 2 when V=0, and 3 when V=1.
- R8: Code 4 branches when N equals V (signed `accA >= opM`). Code 5 branches when N differs from V (signed `accA < opM`).
- R9: Code 6 branches when Z=1 (equal). Code 7 branches when Z=0 (not equal).
- R10: `takeBranch` is combinational from the registered flags and `condSel`. A change of `condSel` shows in the same cycle. A change of `accA` or `opM` without a strobe does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmpStrobe | input | 1 | Load the flags from this cycle's compare |
| accA | input | 8 | Accumulator value (minuend) |
| opM | input | 8 | Operand (subtrahend) |
| condSel | input | 3 | Branch-condition code, 0..7 |
| flagN | output | 1 | Registered negative flag |
| flagV | output | 1 | Registered overflow flag |
| flagZ | output | 1 | Registered zero flag |
| flagC | output | 1 | Registered carry flag (unsigned A >= M) |
| takeBranch | output | 1 | Selected condition holds |

## Verification
The bench targets compares whose signed result overflows: 0x64 vs 0xE2, 0xE2 vs 0x64, 0x7F vs 0xFF and 0x00 vs 0x80. A design that judged signed order from the sign bit alone, or that built overflow from the wrong pair of sign bits, would give the wrong answer on codes 4 and 5 for exactly these cases.

Equal operands, and pairs where signed and unsigned order disagree, expose a carry that is inverted or a zero flag taken from the wrong bits. Further tests cover the following:
- Compares with the strobe low, which catch flags that follow the inputs instead of holding.
- Reset arriving together with a strobe, which catches a reset that loses priority.
- Changing `condSel` alone, which catches a branch output that is registered instead of combinational.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFlags;
    logic clearFlags;
  } flagCtrlT;

  // Registered status flags
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flagSetT;

  // Branch-condition codes
  typedef enum logic [2:0] {
    COND_PLUS   = 3'd0,
    COND_MINUS  = 3'd1,
    COND_VCLR   = 3'd2,
    COND_VSET   = 3'd3,
    COND_SGE    = 3'd4,
    COND_SLT    = 3'd5,
    COND_EQ     = 3'd6,
    COND_NE     = 3'd7
  } condCodeE;

endpackage

// File: rtl/cmpControl.sv
module cmpControl
  import cmp_pkg::*;
(
  input  logic     rst,
  input  logic     cmpStrobe,
  output flagCtrlT ctrl
);

  // Reset wins over a compare in the same cycle
  always_comb begin
    ctrl.clearFlags = rst;
    ctrl.loadFlags  = cmpStrobe & ~rst;
  end

endmodule

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import cmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  flagCtrlT          ctrl,
  input  logic [DATA_W-1:0] accA,
  input  logic [DATA_W-1:0] opM,
  output flagSetT           flags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] diff;
  flagSetT           nextFlags;

  // Subtract by adding the inverted operand plus one
  always_comb begin
    sumWide = {1'b0, accA} + {1'b0, ~opM} + {{DATA_W{1'b0}}, 1'b1};
    diff    = sumWide[DATA_W-1:0];
    nextFlags.n = diff[MSB];
    nextFlags.v = (accA[MSB] ^ opM[MSB]) & (diff[MSB] ^ accA[MSB]);
    nextFlags.z = (diff == '0);
    nextFlags.c = sumWide[DATA_W];
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearFlags) begin
      flags <= '0;
    end else if (ctrl.loadFlags) begin
      flags <= nextFlags;
    end
  end

endmodule

// File: rtl/branchEval.sv
module branchEval
  import cmp_pkg::*;
(
  input  flagSetT    flags,
  input  logic [2:0] condSel,
  output logic       takeBranch
);

  always_comb begin
    case (condCodeE'(condSel))
      COND_PLUS:  takeBranch = ~flags.n;
      COND_MINUS: takeBranch =  flags.n;
      COND_VCLR:  takeBranch = ~flags.v;
      COND_VSET:  takeBranch =  flags.v;
      COND_SGE:   takeBranch = ~(flags.n ^ flags.v);
      COND_SLT:   takeBranch =  (flags.n ^ flags.v);
      COND_EQ:    takeBranch =  flags.z;
      COND_NE:    takeBranch = ~flags.z;
      default:    takeBranch = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmpBranchUnit.sv
module cmpBranchUnit
  import cmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpStrobe,
  input  logic [DATA_W-1:0] accA,
  input  logic [DATA_W-1:0] opM,
  input  logic [2:0]        condSel,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC,
  output logic              takeBranch
);

  flagCtrlT ctrl;
  flagSetT  flags;

  cmpControl i_ctrl (
    .rst       (rst),
    .cmpStrobe (cmpStrobe),
    .ctrl      (ctrl)
  );

  cmpDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk   (clk),
    .ctrl  (ctrl),
    .accA  (accA),
    .opM   (opM),
    .flags (flags)
  );

  branchEval i_br (
    .flags      (flags),
    .condSel    (condSel),
    .takeBranch (takeBranch)
  );

  assign flagN = flags.n;
  assign flagV = flags.v;
  assign flagZ = flags.z;
  assign flagC = flags.c;

endmodule

// File: rtl/cmpBranchChecker.sv
module cmpBranchChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmpStrobe,
  input logic [DATA_W-1:0] accA,
  input logic [DATA_W-1:0] opM,
  input logic [2:0]        condSel,
  input logic              flagN,
  input logic              flagV,
  input logic              flagZ,
  input logic              flagC,
  input logic              takeBranch
);

  localparam int MSB = DATA_W - 1;

  // Check of R6: reset clears everything on the next edge
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> ({flagN, flagV, flagZ, flagC} == 4'b0000));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cmpStrobe |=> $stable({flagN, flagV, flagZ, flagC}));

  p_sign_bit_r1: assert property (@(posedge clk) disable iff (rst)
    cmpStrobe |=> flagN == (($past(accA) - $past(opM)) >> MSB) % 2);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    cmpStrobe |=> flagV == (($signed({$past(accA[MSB]), $past(accA)})
                            - $signed({$past(opM[MSB]), $past(opM)})) >
                           $signed({2'b00, {(DATA_W-1){1'b1}}})
                         || ($signed({$past(accA[MSB]), $past(accA)})
                            - $signed({$past(opM[MSB]), $past(opM)})) <
                           $signed({2'b11, {(DATA_W-1){1'b0}}})));

  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    cmpStrobe |=> flagZ == ($past(accA) == $past(opM)));

  p_carry_r4: assert property (@(posedge clk) disable iff (rst)
    cmpStrobe |=> flagC == ($past(accA) >= $past(opM)));

  p_signed_order_r8: assert property (@(posedge clk) disable iff (rst)
    cmpStrobe |=> (flagN == flagV) ==
                  ($signed($past(accA)) >= $signed($past(opM))));

  p_single_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (condSel == 3'd1) |-> takeBranch == flagN);

  p_equal_r9: assert property (@(posedge clk) disable iff (rst)
    (condSel == 3'd7) |-> takeBranch != flagZ);

endmodule

bind cmpBranchUnit cmpBranchChecker #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cmpStrobe  (cmpStrobe),
  .accA       (accA),
  .opM        (opM),
  .condSel    (condSel),
  .flagN      (flagN),
  .flagV      (flagV),
  .flagZ      (flagZ),
  .flagC      (flagC),
  .takeBranch (takeBranch)
);

// File: tb/test_cmpBranchUnit.sv
module test_cmpBranchUnit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmpStrobe;
  logic [7:0] accA;
  logic [7:0] opM;
  logic [2:0] condSel;
  logic       flagN, flagV, flagZ, flagC, takeBranch;

  int checks = 0;
  int errors = 0;

  // a, m, expected {N,V,Z,C}
  localparam logic [19:0] VECS [NVEC] = '{
    {8'h64, 8'hE2, 4'b1100},
    {8'hE2, 8'h64, 4'b0101},
    {8'hBA, 8'hE2, 4'b1000},
    {8'h46, 8'h1E, 4'b0001},
    {8'h1E, 8'h46, 4'b1000},
    {8'hE2, 8'hBA, 4'b0001},
    {8'h55, 8'h55, 4'b0011},
    {8'h80, 8'h01, 4'b0101},
    {8'h7F, 8'hFF, 4'b1100},
    {8'h00, 8'h00, 4'b0011},
    {8'h00, 8'h80, 4'b1100},
    {8'h01, 8'hFF, 4'b0000}
  };

  cmpBranchUnit i_cmpBranchUnit (
    .clk(clk), .rst(rst), .cmpStrobe(cmpStrobe), .accA(accA), .opM(opM),
    .condSel(condSel), .flagN(flagN), .flagV(flagV), .flagZ(flagZ),
    .flagC(flagC), .takeBranch(takeBranch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expBranch(input logic [3:0] f, input logic [2:0] c);
    case (c)
      3'd0: return ~f[3];
      3'd1: return  f[3];
      3'd2: return ~f[2];
      3'd3: return  f[2];
      3'd4: return ~(f[3] ^ f[2]);
      3'd5: return  (f[3] ^ f[2]);
      3'd6: return  f[1];
      default: return ~f[1];
    endcase
  endfunction

  task automatic checkFlags(input string req, input logic [3:0] exp);
    checks++;
    if ({flagN, flagV, flagZ, flagC} !== exp) begin
      errors++;
      $display("FAIL %s: flags NVZC actual %b expected %b", req,
               {flagN, flagV, flagZ, flagC}, exp);
    end
  endtask

  task automatic checkBranch(input string req, input logic exp);
    checks++;
    if (takeBranch !== exp) begin
      errors++;
      $display("FAIL %s: takeBranch code %0d actual %b expected %b", req,
               condSel, takeBranch, exp);
    end
  endtask

  // Drive a compare at a falling edge; flags load at the next rising edge
  task automatic doCompare(input logic [7:0] a, input logic [7:0] m, input logic strobe);
    @(negedge clk);
    accA = a; opM = m; cmpStrobe = strobe;
    @(negedge clk);
    cmpStrobe = 1'b0;
  endtask

  // Try every condition code against the current flags (R7, R8, R9, R10)
  task automatic sweepCodes(input logic [3:0] f);
    for (int c = 0; c < 8; c++) begin
      condSel = 3'(c);
      #1;
      if (c < 4)      checkBranch("R7", expBranch(f, 3'(c)));
      else if (c < 6) checkBranch("R8", expBranch(f, 3'(c)));
      else            checkBranch("R9", expBranch(f, 3'(c)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cmpStrobe = 1'b0; accA = '0; opM = '0; condSel = '0;
    repeat (2) @(negedge clk);
    checkFlags("R6 reset state", 4'b0000);
    rst = 1'b0;

    // Table walk: R1..R4 flags, then every branch code
    for (int i = 0; i < NVEC; i++) begin
      doCompare(VECS[i][19:12], VECS[i][11:4], 1'b1);
      checkFlags("R1 R2 R3 R4", VECS[i][3:0]);
      sweepCodes(VECS[i][3:0]);
    end

    // R5: inputs change without strobe, flags and branch hold
    doCompare(8'h64, 8'hE2, 1'b1);           // NVZC = 1100
    doCompare(8'h55, 8'h55, 1'b0);
    checkFlags("R5 hold", 4'b1100);
    @(negedge clk);
    accA = 8'h10; opM = 8'h20;
    condSel = 3'd6;
    #1;
    checkBranch("R10 inputs ignored without strobe", 1'b0);
    checkFlags("R5 hold after input change", 4'b1100);

    // R10: condSel change acts in the same cycle
    condSel = 3'd4;
    #1;
    checkBranch("R10 same-cycle select", 1'b1);
    condSel = 3'd5;
    #1;
    checkBranch("R10 same-cycle select", 1'b0);

    // R6: reset wins over a strobe
    @(negedge clk);
    rst = 1'b1; cmpStrobe = 1'b1; accA = 8'hE2; opM = 8'h64;
    @(negedge clk);
    rst = 1'b0; cmpStrobe = 1'b0;
    checkFlags("R6 reset priority", 4'b0000);

    // R3 and R4 again after reset: equal operands
    doCompare(8'hFF, 8'hFF, 1'b1);
    checkFlags("R3 R4 equal", 4'b0011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule